// File: doc/BRIEF.md
# Character-Command JTAG Pin Driver

This block turns a stream of one-byte ASCII commands into JTAG pin activity. Bytes arrive on a valid/ready input. Each accepted byte is decoded at once. Digit commands set the clock, mode-select and data-in pins together. A second group of letters drives the test-reset line. A read letter samples the TDO pin and queues a printable '0' or '1' reply on a valid/ready output. Two letters switch a blink indicator on and off, and one letter reports that the client has left. Any other character is a protocol violation.

A debug agent next to the block can raise a pending flag while one of its transactions is in flight. While the flag is high, the block takes no bytes, so the pin sequence halts until the response returns. The channel that carries the bytes, such as a socket bridge or a UART, sits outside this block.

Top module: `bbj_bitbang_decoder`

## Requirements
- R1: After reset, tck, tms, tdi, trst, blink, proto_err, disconnect and out_valid are all 0. in_ready is 1 while txn_pending is 0.
- R2: An accepted byte in the range 0x30..0x37 ('0'..'7') has the value v = byte - 0x30. On the next cycle tdi = v[0], tms = v[1] and tck = v[2]. trst and blink are left unchanged.
- R3: An accepted byte in the range 0x72..0x75 ('r'..'u') has the value w = byte - 0x72. On the next cycle trst = w[1], so 'r' and 's' give 0 and 't' and 'u' give 1. tck, tms and tdi are left unchanged.
- R4: An accepted 0x52 ('R') samples tdo in the cycle it is accepted. On the next cycle out_valid is 1 and out_data is 0x30 when tdo was 0, or 0x31 when tdo was 1. out_data stays stable until a cycle in which out_ready is 1.
- R5: While out_valid is 1, in_ready is 0, so a reply that has not been taken is never overwritten.
- R6: An accepted 0x42 ('B') sets blink to 1 on the next cycle. An accepted 0x62 ('b') clears blink to 0 on the next cycle.
- R7: An accepted 0x51 ('Q') pulses disconnect for exactly the next cycle and leaves the pins unchanged. disconnect is never 1 in any other case.
- R8: An accepted byte outside all of the codes above sets proto_err on the next cycle. proto_err then stays 1 until reset.
- R9: While proto_err is 1, in_ready still follows R5 and R10. Every accepted byte is discarded: the pins and blink do not change, no reply is produced, and disconnect stays 0.
- R10: While txn_pending is 1, in_ready is 0 and no byte is consumed. A byte held on the input is taken after txn_pending falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Command byte is present |
| in_data | input | BYTE_W | Command byte |
| in_ready | output | 1 | Block can take a byte this cycle |
| out_valid | output | 1 | Reply byte is present |
| out_data | output | BYTE_W | Reply byte ('0' or '1') |
| out_ready | input | 1 | Receiver takes the reply |
| txn_pending | input | 1 | Downstream debug transaction is in flight |
| tdo | input | 1 | JTAG data from the target |
| tck | output | 1 | JTAG clock pin |
| tms | output | 1 | JTAG mode-select pin |
| tdi | output | 1 | JTAG data to the target |
| trst | output | 1 | JTAG test reset, active high |
| blink | output | 1 | Status indicator |
| proto_err | output | 1 | Sticky protocol violation flag |
| disconnect | output | 1 | One-cycle pulse when the client leaves |

## Verification
Two events can fall on the same clock edge: the pending flag rises, and a byte is offered. The bench provokes this by raising txn_pending and presenting an illegal byte at the same falling edge. It then checks that proto_err stays low and the byte stays unconsumed while the flag is high, and that the error appears only after the flag falls. A second collision holds a reply unread while further bytes wait. The bench judges it by whether in_ready stays low and the queued reply value survives until the receiver is released.

// File: rtl/bbj_pkg.sv
package bbj_pkg;
  typedef enum logic [2:0] {
    K_PIN, K_RST, K_READ, K_LED_ON, K_LED_OFF, K_QUIT, K_BAD
  } cmd_kind_e;

  localparam logic [7:0] CH_PIN_LO = 8'h30;
  localparam logic [7:0] CH_PIN_HI = 8'h37;
  localparam logic [7:0] CH_RST_LO = 8'h72;
  localparam logic [7:0] CH_RST_HI = 8'h75;
  localparam logic [7:0] CH_READ   = 8'h52;
  localparam logic [7:0] CH_LED_ON = 8'h42;
  localparam logic [7:0] CH_LED_OF = 8'h62;
  localparam logic [7:0] CH_QUIT   = 8'h51;
endpackage

// File: rtl/bbj_classify.sv
module bbj_classify
  import bbj_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] code,
  output cmd_kind_e         kind,
  output logic [2:0]        arg
);
  localparam int EXT_W = BYTE_W - 8;

  logic [BYTE_W-1:0] pin_off, rst_off;

  assign pin_off = code - {{EXT_W{1'b0}}, CH_PIN_LO};
  assign rst_off = code - {{EXT_W{1'b0}}, CH_RST_LO};

  always_comb begin
    kind = K_BAD;
    arg  = 3'd0;
    if (code >= {{EXT_W{1'b0}}, CH_PIN_LO} && code <= {{EXT_W{1'b0}}, CH_PIN_HI}) begin
      kind = K_PIN;
      arg  = pin_off[2:0];
    end else if (code >= {{EXT_W{1'b0}}, CH_RST_LO} && code <= {{EXT_W{1'b0}}, CH_RST_HI}) begin
      kind = K_RST;
      arg  = rst_off[2:0];
    end else if (code == {{EXT_W{1'b0}}, CH_READ}) begin
      kind = K_READ;
    end else if (code == {{EXT_W{1'b0}}, CH_LED_ON}) begin
      kind = K_LED_ON;
    end else if (code == {{EXT_W{1'b0}}, CH_LED_OF}) begin
      kind = K_LED_OFF;
    end else if (code == {{EXT_W{1'b0}}, CH_QUIT}) begin
      kind = K_QUIT;
    end
  end
endmodule

// File: rtl/bbj_pin_bank.sv
module bbj_pin_bank (
  input  logic       clk,
  input  logic       rst,
  input  logic       load_pins,
  input  logic [2:0] pin_val,
  input  logic       load_trst,
  input  logic       trst_val,
  input  logic       led_on,
  input  logic       led_off,
  output logic       tck,
  output logic       tms,
  output logic       tdi,
  output logic       trst,
  output logic       blink
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tck   <= 1'b0;
      tms   <= 1'b0;
      tdi   <= 1'b0;
      trst  <= 1'b0;
      blink <= 1'b0;
    end else begin
      if (load_pins) begin
        tck <= pin_val[2];
        tms <= pin_val[1];
        tdi <= pin_val[0];
      end
      if (load_trst) trst <= trst_val;
      if (led_on) blink <= 1'b1;
      else if (led_off) blink <= 1'b0;
    end
  end
endmodule

// File: rtl/bbj_reply_slot.sv
module bbj_reply_slot #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              bit_val,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data
);
  localparam logic [BYTE_W-1:0] ASCII_ZERO = BYTE_W'(8'h30);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= ASCII_ZERO;
    end else if (push) begin
      out_valid <= 1'b1;
      out_data  <= ASCII_ZERO + BYTE_W'(bit_val);
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/bbj_bitbang_decoder.sv
module bbj_bitbang_decoder
  import bbj_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  input  logic              out_ready,
  input  logic              txn_pending,
  input  logic              tdo,
  output logic              tck,
  output logic              tms,
  output logic              tdi,
  output logic              trst,
  output logic              blink,
  output logic              proto_err,
  output logic              disconnect
);
  cmd_kind_e  kind;
  logic [2:0] arg;
  logic       accept, live;

  bbj_classify #(.BYTE_W(BYTE_W)) u_cls (
    .code(in_data), .kind(kind), .arg(arg)
  );

  assign in_ready = !txn_pending && !out_valid;
  assign accept   = in_valid && in_ready;
  assign live     = accept && !proto_err;

  bbj_pin_bank u_pins (
    .clk(clk), .rst(rst),
    .load_pins(live && kind == K_PIN), .pin_val(arg),
    .load_trst(live && kind == K_RST), .trst_val(arg[1]),
    .led_on(live && kind == K_LED_ON), .led_off(live && kind == K_LED_OFF),
    .tck(tck), .tms(tms), .tdi(tdi), .trst(trst), .blink(blink)
  );

  bbj_reply_slot #(.BYTE_W(BYTE_W)) u_reply (
    .clk(clk), .rst(rst),
    .push(live && kind == K_READ), .bit_val(tdo),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      proto_err  <= 1'b0;
      disconnect <= 1'b0;
    end else begin
      if (live && kind == K_BAD) proto_err <= 1'b1;
      disconnect <= live && kind == K_QUIT;
    end
  end
endmodule

// File: rtl/bbj_bitbang_checker.sv
module bbj_bitbang_checker #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [BYTE_W-1:0] in_data,
  input logic              in_ready,
  input logic              out_valid,
  input logic [BYTE_W-1:0] out_data,
  input logic              out_ready,
  input logic              txn_pending,
  input logic              tck,
  input logic              tms,
  input logic              tdi,
  input logic              trst,
  input logic              blink,
  input logic              proto_err,
  input logic              disconnect
);
  p_reply_blocks_input_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  p_pending_stalls_r10: assert property (@(posedge clk) disable iff (rst)
    txn_pending |-> !in_ready);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> proto_err);

  p_reply_held_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_reply_ascii_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_data == BYTE_W'(8'h30) || out_data == BYTE_W'(8'h31)));

  p_disc_source_r7: assert property (@(posedge clk) disable iff (rst)
    disconnect |-> $past(in_valid && in_ready && in_data == BYTE_W'(8'h51)));

  p_drop_after_err_r9: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> ($stable({tck, tms, tdi, trst, blink}) && !disconnect));
endmodule

bind bbj_bitbang_decoder bbj_bitbang_checker #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
  .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
  .out_ready(out_ready), .txn_pending(txn_pending), .tck(tck), .tms(tms),
  .tdi(tdi), .trst(trst), .blink(blink), .proto_err(proto_err),
  .disconnect(disconnect)
);

// File: tb/tb_bbj_bitbang_decoder.sv
module tb_bbj_bitbang_decoder;
  localparam int BW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [BW-1:0] in_data = '0;
  logic in_ready, out_valid, out_ready = 1'b1;
  logic [BW-1:0] out_data;
  logic txn_pending = 1'b0, tdo = 1'b0;
  logic tck, tms, tdi, trst, blink, proto_err, disconnect;

  int checks = 0;
  int errors = 0;
  logic [BW-1:0] exp_q[$];
  int popped = 0;

  always #4 clk = ~clk;

  bbj_bitbang_decoder #(.BYTE_W(BW)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .txn_pending(txn_pending), .tdo(tdo),
    .tck(tck), .tms(tms), .tdi(tdi), .trst(trst), .blink(blink),
    .proto_err(proto_err), .disconnect(disconnect)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: each reply transfer is compared with the queue head.
  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      if (exp_q.size() == 0) chk(1'b0, "R4 unexpected reply", int'(out_data), 0);
      else begin
        logic [BW-1:0] e;
        e = exp_q.pop_front();
        popped++;
        chk(out_data == e, "R4 reply byte", int'(out_data), int'(e));
      end
    end
  end

  task automatic send(input logic [BW-1:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pins(input logic [2:0] e, input string req);
    chk({tck, tms, tdi} == e, req, int'({tck, tms, tdi}), int'(e));
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({tck, tms, tdi, trst, blink, proto_err, disconnect, out_valid} == 8'h00,
        "R1 reset outputs", int'({tck, tms, tdi, trst, blink, proto_err, disconnect, out_valid}), 0);
    chk(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);

    // R2 pin patterns
    send("5"); pins(3'b101, "R2 char 5");
    send("2"); pins(3'b010, "R2 char 2");
    send("7"); pins(3'b111, "R2 char 7");
    send("0"); pins(3'b000, "R2 char 0");
    send("6"); pins(3'b110, "R2 char 6");

    // R3 reset letters, pins untouched
    send("u"); chk(trst == 1'b1, "R3 u", int'(trst), 1); pins(3'b110, "R3 pins kept");
    send("s"); chk(trst == 1'b0, "R3 s", int'(trst), 0);
    send("t"); chk(trst == 1'b1, "R3 t", int'(trst), 1);
    send("r"); chk(trst == 1'b0, "R3 r", int'(trst), 0);

    // R4 reads through the scoreboard
    tdo = 1'b1; exp_q.push_back(8'h31); send("R");
    tdo = 1'b0; exp_q.push_back(8'h30); send("R");
    @(negedge clk);

    // R5 reply held while receiver stalls
    out_ready = 1'b0;
    tdo = 1'b1; exp_q.push_back(8'h31); send("R");
    repeat (3) begin
      chk(out_valid == 1'b1, "R5 reply held", int'(out_valid), 1);
      chk(in_ready == 1'b0, "R5 input blocked", int'(in_ready), 0);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    chk(popped == 3, "R4 reply count", popped, 3);

    // R6 blink
    send("B"); chk(blink == 1'b1, "R6 blink on", int'(blink), 1);
    send("b"); chk(blink == 1'b0, "R6 blink off", int'(blink), 0);

    // R7 disconnect pulse
    send("Q");
    chk(disconnect == 1'b1, "R7 pulse", int'(disconnect), 1);
    pins(3'b110, "R7 pins kept");
    @(negedge clk);
    chk(disconnect == 1'b0, "R7 pulse ends", int'(disconnect), 0);

    // R10 pending stall on a pin command
    txn_pending = 1'b1;
    fork
      send("3");
      begin
        repeat (4) @(negedge clk);
        chk(in_ready == 1'b0, "R10 ready low", int'(in_ready), 0);
        pins(3'b110, "R10 held byte not applied");
        txn_pending = 1'b0;
      end
    join
    pins(3'b011, "R10 byte taken after release");

    // R8/R10 collision: pending rises as an illegal byte is offered
    @(negedge clk);
    txn_pending = 1'b1;
    in_valid = 1'b1;
    in_data  = "Z";
    repeat (3) @(negedge clk);
    chk(proto_err == 1'b0, "R10 illegal byte not consumed", int'(proto_err), 0);
    txn_pending = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    chk(proto_err == 1'b1, "R8 error raised", int'(proto_err), 1);

    // R9 bytes dropped after error
    send("4"); pins(3'b011, "R9 pins frozen");
    send("B"); chk(blink == 1'b0, "R9 blink frozen", int'(blink), 0);
    send("R");
    chk(out_valid == 1'b0, "R9 no reply", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R9 still ready", int'(in_ready), 1);
    send("Q");
    chk(disconnect == 1'b0, "R9 no disconnect", int'(disconnect), 0);
    repeat (2) @(negedge clk);
    chk(proto_err == 1'b1, "R8 error sticky", int'(proto_err), 1);
    chk(exp_q.size() == 0, "R4 queue drained", exp_q.size(), 0);

    finish_run();
  end
endmodule